// File: doc/BRIEF.md
# Cache Transaction Event Counter Bank

This block holds one cluster's counters for cache traffic. Four free-running counters each track a fixed class of coherent-protocol transactions. Two watch the memory-side interface, one for reads and one for write-backs. One watches snoop reads that the interconnect sends into the cluster. One watches writes that enter the cluster through its coherency port. Transactions arrive as a single valid strobe with a 4-bit opcode and a 2-bit path code. On a cycle with the strobe high, every enabled counter whose class contains that opcode on that path goes up by one.

Software turns a counter on or off by writing a packed event code. The code is accepted only when it names a transaction counter and gives that counter's own enable-bit position; any other code is dropped. Counts are cleared by writing a mask of clear bits. They are read back through an index with one cycle of latency. Counting is the only mode: there is no sampling and no overflow interrupt.

Top module: `cache_evt_bank`

## Requirements
- R1: Counter 0 (memory read) increments on opcodes 1 (shared read), 2 (unique read), 3 (clean read) and 4 (read not-shared-dirty) when txn_path is 0 (memory side).
- R2: Counter 1 (memory write) increments on opcodes 8 (write-back), 9 (write-clean) and 10 (write-evict) when txn_path is 0.
- R3: Counter 2 (snoop read) increments on opcodes 0 (read-once), 1, 2, 3 and 4 when txn_path is 1 (interconnect to cluster).
- R4: Counter 3 (coherency-port write) increments on opcodes 8, 9 and 10 when txn_path is 2 (coherency port).
- R5: Opcodes 5-7 and 11-15, any transaction on path 3, and any opcode that belongs to a class but arrives on another counter's path leave every counter unchanged.
- R6: An event write applies evt_set (1 enables, 0 disables) to the counter named by evt_code bits [4:1]. Bit 0 must be 0, which selects the transaction group, and bits [9:5] must equal EN_LSB plus the index. EN_LSB defaults to 8.
- R7: An event write is ignored if evt_code bit 0 is 1 (tenure group), if the index is 4 or more, or if the bit position is not EN_LSB plus the index.
- R8: A counter increments by exactly one on each clock edge where txn_valid is high, its class matches and it is enabled. It does not change while txn_valid is low or while it is disabled.
- R9: Each counter is CNT_W bits wide (32 by default) and wraps from all ones to zero.
- R10: A clr_wr with clr_mask bit i set zeroes counter i on that edge, even if counter i would also increment. Counters whose mask bit is clear are not affected.
- R11: rd_data shows counter rd_idx one clock after rd_idx is presented. It shows zero for an index of 4 or more.
- R12: After reset every counter reads zero and every counter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transaction strobe, one transaction per high cycle |
| txn_path | input | 2 | 0 memory side, 1 snoop into cluster, 2 coherency port, 3 none |
| txn_opcode | input | 4 | Transaction opcode |
| evt_wr | input | 1 | Event code write strobe |
| evt_set | input | 1 | 1 enables, 0 disables the addressed counter |
| evt_code | input | 10 | Packed event code: group, index, enable-bit position |
| clr_wr | input | 1 | Clear strobe |
| clr_mask | input | 4 | One clear bit per counter |
| rd_idx | input | 4 | Counter index to read |
| rd_data | output | CNT_W | Registered count of the indexed counter |

## Verification
The bench targets the opcode-class edges: read-once counts as a snoop read but not as a memory read; write opcodes on the snoop path count nowhere; so do the reserved opcodes and path 3. A decoder with a wrong class table would bump the wrong counter, and the bench catches this against its own model. It writes event codes that are wrong in the group bit, the index or the bit position, and checks that the enable state does not change. A design that decodes too loosely would stop or start counting. It also sends a clear and a matching transaction on the same edge, where clear must win. It runs a narrow counter instance past its maximum to show the wrap. It reads out-of-range indices, where stale or aliased data would show up.

// File: rtl/cache_evt_pkg.sv
`timescale 1ns/1ps
package cache_evt_pkg;
  localparam int NUM_CTR = 4;
  localparam int IDX_W   = 4;
  localparam int POS_W   = 5;
  localparam int CODE_W  = 1 + IDX_W + POS_W;

  // counter slots
  localparam int CTR_MEM_RD = 0;
  localparam int CTR_MEM_WR = 1;
  localparam int CTR_SNP_RD = 2;
  localparam int CTR_CP_WR  = 3;

  // path codes
  localparam logic [1:0] PATH_MEM  = 2'd0;
  localparam logic [1:0] PATH_SNP  = 2'd1;
  localparam logic [1:0] PATH_CP   = 2'd2;

  // opcode codes
  localparam logic [3:0] OP_RD_ONCE   = 4'd0;
  localparam logic [3:0] OP_RD_SHARED = 4'd1;
  localparam logic [3:0] OP_RD_NSD    = 4'd4;
  localparam logic [3:0] OP_WR_BACK   = 4'd8;
  localparam logic [3:0] OP_WR_EVICT  = 4'd10;
endpackage

// File: rtl/txn_class_decode.sv
`timescale 1ns/1ps
module txn_class_decode
  import cache_evt_pkg::*;
(
  input  logic               valid,
  input  logic [1:0]         path,
  input  logic [3:0]         opcode,
  output logic [NUM_CTR-1:0] hit
);
  logic rd_cls, once_op, wr_cls;

  always_comb begin
    rd_cls  = (opcode >= OP_RD_SHARED) && (opcode <= OP_RD_NSD);
    once_op = (opcode == OP_RD_ONCE);
    wr_cls  = (opcode >= OP_WR_BACK) && (opcode <= OP_WR_EVICT);
    hit = '0;
    if (valid) begin
      hit[CTR_MEM_RD] = (path == PATH_MEM) && rd_cls;
      hit[CTR_MEM_WR] = (path == PATH_MEM) && wr_cls;
      hit[CTR_SNP_RD] = (path == PATH_SNP) && (rd_cls || once_op);
      hit[CTR_CP_WR]  = (path == PATH_CP)  && wr_cls;
    end
  end
endmodule

// File: rtl/evt_enable_ctrl.sv
`timescale 1ns/1ps
module evt_enable_ctrl
  import cache_evt_pkg::*;
#(
  parameter int EN_LSB = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_wr,
  input  logic               evt_set,
  input  logic [CODE_W-1:0]  evt_code,
  output logic [NUM_CTR-1:0] ena
);
  logic              grp;
  logic [IDX_W-1:0]  idx;
  logic [POS_W-1:0]  pos;
  logic              code_ok;
  logic [NUM_CTR-1:0] ena_d, ena_q;

  always_comb begin
    grp     = evt_code[0];
    idx     = evt_code[IDX_W:1];
    pos     = evt_code[CODE_W-1:IDX_W+1];
    code_ok = !grp && (int'(idx) < NUM_CTR) && (int'(pos) == EN_LSB + int'(idx));
    ena_d   = ena_q;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (evt_wr && code_ok && (int'(idx) == i)) ena_d[i] = evt_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (evt_wr) ena_q <= ena_d;
  end

  assign ena = ena_q;
endmodule

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc || clr;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cache_evt_bank.sv
`timescale 1ns/1ps
module cache_evt_bank
  import cache_evt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int EN_LSB = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_valid,
  input  logic [1:0]          txn_path,
  input  logic [3:0]          txn_opcode,
  input  logic                evt_wr,
  input  logic                evt_set,
  input  logic [CODE_W-1:0]   evt_code,
  input  logic                clr_wr,
  input  logic [NUM_CTR-1:0]  clr_mask,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CNT_W-1:0]    rd_data
);
  logic [NUM_CTR-1:0]            hit;
  logic [NUM_CTR-1:0]            ena_q;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0]              rd_d, rd_q;

  txn_class_decode i_decode (
    .valid  (txn_valid),
    .path   (txn_path),
    .opcode (txn_opcode),
    .hit    (hit)
  );

  evt_enable_ctrl #(.EN_LSB(EN_LSB)) i_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_wr   (evt_wr),
    .evt_set  (evt_set),
    .evt_code (evt_code),
    .ena      (ena_q)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (hit[i] && ena_q[i]),
      .clr   (clr_wr && clr_mask[i]),
      .cnt   (cnt_q[i])
    );
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (int'(rd_idx) == i) rd_d = cnt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/cache_evt_bank_chk.sv
`timescale 1ns/1ps
module cache_evt_bank_chk
  import cache_evt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            txn_valid,
  input logic [1:0]                      txn_path,
  input logic                            clr_wr,
  input logic [NUM_CTR-1:0]              clr_mask,
  input logic [IDX_W-1:0]                rd_idx,
  input logic [CNT_W-1:0]                rd_data,
  input logic [NUM_CTR-1:0]              ena_q,
  input logic [NUM_CTR-1:0][CNT_W-1:0]   cnt_q
);
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_c
    // R8
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_wr && clr_mask[i]) |=>
        (cnt_q[i] == $past(cnt_q[i])) || (cnt_q[i] == $past(cnt_q[i]) + 1'b1));
    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[i]) |=> (cnt_q[i] == '0));
    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ena_q[i] && !(clr_wr && clr_mask[i])) |=> $stable(cnt_q[i]));
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_valid && !clr_wr) |=> $stable(cnt_q));

  // R5
  no_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_path == 2'd3 && !clr_wr) |=> $stable(cnt_q));

  // R11
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= NUM_CTR) |=> (rd_data == '0));
endmodule

bind cache_evt_bank cache_evt_bank_chk #(.CNT_W(CNT_W)) i_cache_evt_bank_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_valid (txn_valid),
  .txn_path  (txn_path),
  .clr_wr    (clr_wr),
  .clr_mask  (clr_mask),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .ena_q     (ena_q),
  .cnt_q     (cnt_q)
);

// File: tb/test_cache_evt_bank.sv
`timescale 1ns/1ps
module test_cache_evt_bank;
  localparam int NW = 4;

  logic        clk, rst_n;
  logic        txn_valid, evt_wr, evt_set, clr_wr;
  logic [1:0]  txn_path;
  logic [3:0]  txn_opcode, clr_mask, rd_idx;
  logic [9:0]  evt_code;
  logic [31:0] rd_data;
  logic [NW-1:0] rd_data_n;

  int checks = 0, fails = 0;
  int exp_cnt [4];
  bit en_m [4];

  cache_evt_bank i_cache_evt_bank (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_path(txn_path),
    .txn_opcode(txn_opcode), .evt_wr(evt_wr), .evt_set(evt_set),
    .evt_code(evt_code), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .rd_idx(rd_idx), .rd_data(rd_data));

  cache_evt_bank #(.CNT_W(NW)) i_cache_evt_bank_narrow (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_path(txn_path),
    .txn_opcode(txn_opcode), .evt_wr(evt_wr), .evt_set(evt_set),
    .evt_code(evt_code), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .rd_idx(rd_idx), .rd_data(rd_data_n));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int cls(logic [1:0] p, logic [3:0] op);
    if (p == 2'd0 && op >= 4'd1 && op <= 4'd4) return 0;
    if (p == 2'd0 && op >= 4'd8 && op <= 4'd10) return 1;
    if (p == 2'd1 && op <= 4'd4) return 2;
    if (p == 2'd2 && op >= 4'd8 && op <= 4'd10) return 3;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk); rd_idx = 4'(idx);
    @(negedge clk); v = rd_data;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      chk(req, v, 32'(exp_cnt[i]));
    end
  endtask

  task automatic send(logic [1:0] p, logic [3:0] op);
    int c;
    @(negedge clk);
    txn_valid = 1'b1; txn_path = p; txn_opcode = op;
    @(negedge clk);
    txn_valid = 1'b0;
    c = cls(p, op);
    if (c >= 0 && en_m[c]) exp_cnt[c]++;
  endtask

  task automatic evt(bit set, logic [9:0] code);
    @(negedge clk);
    evt_wr = 1'b1; evt_set = set; evt_code = code;
    @(negedge clk);
    evt_wr = 1'b0;
  endtask

  function automatic logic [9:0] good_code(int i);
    return {5'(8 + i), 4'(i), 1'b0};
  endfunction

  task automatic t_reset();
    // R12: zero after reset and disabled
    check_all("R12");
    send(2'd0, 4'd1);
    send(2'd1, 4'd0);
    check_all("R12");
  endtask

  task automatic t_enable();
    // R6: correct codes enable all four
    for (int i = 0; i < 4; i++) begin
      evt(1'b1, good_code(i));
      en_m[i] = 1'b1;
    end
    send(2'd0, 4'd2);
    send(2'd1, 4'd2);
    check_all("R6");
  endtask

  task automatic t_classes();
    // R1
    for (int op = 0; op < 5; op++) send(2'd0, 4'(op));
    check_all("R1");
    // R2
    for (int op = 8; op < 11; op++) send(2'd0, 4'(op));
    check_all("R2");
    // R3
    for (int op = 0; op < 5; op++) send(2'd1, 4'(op));
    for (int op = 8; op < 11; op++) send(2'd1, 4'(op));
    check_all("R3");
    // R4
    for (int op = 8; op < 11; op++) send(2'd2, 4'(op));
    for (int op = 0; op < 5; op++) send(2'd2, 4'(op));
    check_all("R4");
  endtask

  task automatic t_unmatched();
    // R5: reserved opcodes, path 3
    for (int p = 0; p < 3; p++) begin
      for (int op = 5; op < 8; op++) send(2'(p), 4'(op));
      for (int op = 11; op < 16; op++) send(2'(p), 4'(op));
    end
    for (int op = 0; op < 16; op++) send(2'd3, 4'(op));
    check_all("R5");
  endtask

  task automatic t_bad_codes();
    // R7: all ignored, counter 0 stays enabled
    evt(1'b0, good_code(0) | 10'd1);
    evt(1'b0, {5'd17, 4'd9, 1'b0});
    evt(1'b0, {5'd9, 4'd0, 1'b0});
    evt(1'b0, {5'd8, 4'd4, 1'b0});
    send(2'd0, 4'd3);
    check_all("R7");
    // R6: proper disable
    evt(1'b0, good_code(0));
    en_m[0] = 1'b0;
    send(2'd0, 4'd3);
    send(2'd0, 4'd4);
    check_all("R6");
    evt(1'b1, good_code(0));
    en_m[0] = 1'b1;
  endtask

  task automatic t_burst();
    // R8: valid held 5 cycles -> +5
    @(negedge clk);
    txn_valid = 1'b1; txn_path = 2'd0; txn_opcode = 4'd1;
    repeat (5) @(negedge clk);
    txn_valid = 1'b0;
    exp_cnt[0] += 5;
    // R8: matching opcode with valid low
    repeat (3) @(negedge clk);
    check_all("R8");
  endtask

  task automatic t_clear();
    // R10: masked clear only
    @(negedge clk); clr_wr = 1'b1; clr_mask = 4'b0010;
    @(negedge clk); clr_wr = 1'b0;
    exp_cnt[1] = 0;
    check_all("R10");
    // R10: clear beats increment on same edge
    @(negedge clk);
    clr_wr = 1'b1; clr_mask = 4'b0001;
    txn_valid = 1'b1; txn_path = 2'd0; txn_opcode = 4'd2;
    @(negedge clk);
    clr_wr = 1'b0; txn_valid = 1'b0;
    exp_cnt[0] = 0;
    check_all("R10");
  endtask

  task automatic t_oob_read();
    logic [31:0] v;
    // R11
    rd(4, v);  chk("R11", v, 32'd0);
    rd(15, v); chk("R11", v, 32'd0);
    rd(2, v);  chk("R11", v, 32'(exp_cnt[2]));
  endtask

  task automatic t_wrap();
    // R9: narrow instance wraps after 2**NW increments
    @(negedge clk); clr_wr = 1'b1; clr_mask = 4'b1111;
    @(negedge clk); clr_wr = 1'b0;
    for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
    for (int k = 0; k < 17; k++) send(2'd0, 4'd9);
    @(negedge clk); rd_idx = 4'd1;
    @(negedge clk);
    chk("R9", 32'(rd_data_n), 32'd1);
    chk("R9", rd_data, 32'd17);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; txn_valid = 1'b0; txn_path = 2'd0; txn_opcode = 4'd0;
    evt_wr = 1'b0; evt_set = 1'b0; evt_code = '0; clr_wr = 1'b0;
    clr_mask = '0; rd_idx = '0;
    for (int i = 0; i < 4; i++) begin exp_cnt[i] = 0; en_m[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_enable();
    t_classes();
    t_unmatched();
    t_bad_codes();
    t_burst();
    t_clear();
    t_oob_read();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule